// File: doc/BRIEF.md
# Ethernet DMA Control and Status Registers

This block is the software-visible register file that sits in front of an Ethernet DMA engine. A processor reaches it over a simple 32-bit word bus. The byte address is shifted right by two to form a word index. The block holds the settings the engine needs:

- bus mode
- ring base addresses
- current descriptor pointers
- run control
- interrupt enables

It also gathers completion events from the transmit and receive engines into a status word. One level interrupt is raised from that status word.

Software starts the transmitter by writing to a strobe location. Acknowledging an event means writing ones to the status word. Writing a ring base also rewinds the matching current descriptor pointer, so the engine starts again at the top of the ring. Word indices that have no dedicated meaning are kept as plain storage up to a fixed array size. Indices above that size read as zero.

The bus accepts one access on every cycle and never stalls. A read returns its data one cycle later, marked by a valid pulse. The event inputs and the control outputs are plain level or pulse pins with no handshake.

Top module: `eth_dma_csr`

## Requirements
- R1: After reset every register reads 0 and `irq`, `tx_poll`, `rx_enable` and `tx_start` are 0.
- R2: A read accepted in cycle N raises `rd_valid` in cycle N+1, with `rd_data` holding the value the register had before that edge. The word index is `bus_addr[ADDR_W-1:2]`.
- R3: A write to index 0x3C5 (status) clears each status bit whose write-data bit is 1 and leaves the other status bits unchanged.
- R4: A one-cycle event sets status bits one edge later: `evt_tx_done` sets bits 0 and 16, `evt_rx_done` sets bits 6 and 16, and `evt_rx_nobuf` sets bits 7 and 15.
- R5: When an event and a software clear of the same bit meet in one cycle, the bit ends up set.
- R6: `irq` is 1 exactly when status AND interrupt-enable (index 0x3C7) is nonzero.
- R7: A write to index 0x3C3 (rx ring base) also loads the rx descriptor pointer (index 0x3D3). A write to index 0x3C4 (tx ring base) also loads the tx descriptor pointer (index 0x3D2). Both pointers can also be written directly.
- R8: A write to index 0x3C1 stores nothing; reading it back gives 0. The write raises `tx_poll` for exactly one cycle, in the cycle after the write.
- R9: A write to index 0x3C0 (bus mode) stores the data with bit 0 forced to 0.
- R10: Index 8 always reads 0x1012, and writes to it have no effect.
- R11: `rx_enable` follows bit 1 of the control register (index 0x3C6), and `tx_start` follows bit 13.
- R12: Other indices below `STORE_WORDS` (1024) read back the last value written to them. Indices at or above 1024 read 0, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle (always accepted) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after read) |
| rd_data | output | 32 | Read data |
| evt_tx_done | input | 1 | Transmit frame completed pulse |
| evt_rx_done | input | 1 | Receive frame completed pulse |
| evt_rx_nobuf | input | 1 | Receive found no free descriptor pulse |
| irq | output | 1 | Level interrupt |
| tx_poll | output | 1 | One-cycle transmit poll-demand strobe |
| rx_enable | output | 1 | Receive run control |
| tx_start | output | 1 | Transmit run control |
| rx_ring_base | output | 32 | Rx ring base address |
| tx_ring_base | output | 32 | Tx ring base address |
| rx_desc_ptr | output | 32 | Current rx descriptor pointer |
| tx_desc_ptr | output | 32 | Current tx descriptor pointer |

## Verification
The status word is tried three ways:

- Single events alone show that each event sets its own bit pair.
- Partial write-one clears show that unselected bits survive a clear.
- An event that lands in the same cycle as a clear of its own bit shows whether set or clear wins.

Interrupt enables are switched between a normal bit and a summary bit. This shows whether `irq` depends on enabled bits only.

Accesses are made to three kinds of index. Special indices (the poll strobe, the version word, the bus-mode word, the ring bases) show writes that are redirected or masked. Ordinary indices below the array size are then compared with indices above it, which tells plain storage apart from unmapped space.

// File: rtl/eth_dma_csr_pkg.sv
package eth_dma_csr_pkg;

  localparam int unsigned IX_VERSION  = 'h008;
  localparam int unsigned IX_BUSMODE  = 'h3C0;
  localparam int unsigned IX_TXPOLL   = 'h3C1;
  localparam int unsigned IX_RXBASE   = 'h3C3;
  localparam int unsigned IX_TXBASE   = 'h3C4;
  localparam int unsigned IX_STATUS   = 'h3C5;
  localparam int unsigned IX_CTRL     = 'h3C6;
  localparam int unsigned IX_INTEN    = 'h3C7;
  localparam int unsigned IX_TXCUR    = 'h3D2;
  localparam int unsigned IX_RXCUR    = 'h3D3;

  localparam logic [31:0] VERSION_WORD = 32'h0000_1012;

  // status bit positions
  localparam int unsigned ST_TX_DONE  = 0;
  localparam int unsigned ST_RX_DONE  = 6;
  localparam int unsigned ST_RX_NOBUF = 7;
  localparam int unsigned ST_ABNORMAL = 15;
  localparam int unsigned ST_NORMAL   = 16;

  // control bit positions
  localparam int unsigned CT_RX_RUN = 1;
  localparam int unsigned CT_TX_RUN = 13;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_VERSION,
    SEL_BUSMODE,
    SEL_TXPOLL,
    SEL_RXBASE,
    SEL_TXBASE,
    SEL_STATUS,
    SEL_CTRL,
    SEL_INTEN,
    SEL_TXCUR,
    SEL_RXCUR,
    SEL_STORE
  } csr_sel_e;

endpackage

// File: rtl/eth_dma_csr_decode.sv
module eth_dma_csr_decode
  import eth_dma_csr_pkg::*;
#(
  parameter int unsigned IDX_W       = 12,
  parameter int unsigned STORE_WORDS = 1024
) (
  input  logic [IDX_W-1:0] idx,
  output csr_sel_e         sel
);

  always_comb begin
    if      (idx == IDX_W'(IX_VERSION)) sel = SEL_VERSION;
    else if (idx == IDX_W'(IX_BUSMODE)) sel = SEL_BUSMODE;
    else if (idx == IDX_W'(IX_TXPOLL))  sel = SEL_TXPOLL;
    else if (idx == IDX_W'(IX_RXBASE))  sel = SEL_RXBASE;
    else if (idx == IDX_W'(IX_TXBASE))  sel = SEL_TXBASE;
    else if (idx == IDX_W'(IX_STATUS))  sel = SEL_STATUS;
    else if (idx == IDX_W'(IX_CTRL))    sel = SEL_CTRL;
    else if (idx == IDX_W'(IX_INTEN))   sel = SEL_INTEN;
    else if (idx == IDX_W'(IX_TXCUR))   sel = SEL_TXCUR;
    else if (idx == IDX_W'(IX_RXCUR))   sel = SEL_RXCUR;
    else if ({20'd0, idx} < 32'(STORE_WORDS)) sel = SEL_STORE;
    else                                sel = SEL_NONE;
  end

endmodule

// File: rtl/eth_dma_csr_status.sv
module eth_dma_csr_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_mask,
  output logic [W-1:0] status
);

  // one cell per bit: a set in the same cycle overrides a clear
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        status[b] <= 1'b0;
      else
        status[b] <= set_mask[b] | (status[b] & ~(clr_en & clr_mask[b]));
    end
  end

endmodule

// File: rtl/eth_dma_csr_store.sv
module eth_dma_csr_store #(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/eth_dma_csr.sv
module eth_dma_csr
  import eth_dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned STORE_WORDS = 1024,
  localparam int unsigned IDX_W      = ADDR_W - 2,
  localparam int unsigned STORE_AW   = $clog2(STORE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              evt_tx_done,
  input  logic              evt_rx_done,
  input  logic              evt_rx_nobuf,
  output logic              irq,
  output logic              tx_poll,
  output logic              rx_enable,
  output logic              tx_start,
  output logic [31:0]       rx_ring_base,
  output logic [31:0]       tx_ring_base,
  output logic [31:0]       rx_desc_ptr,
  output logic [31:0]       tx_desc_ptr
);

  logic [IDX_W-1:0] idx;
  logic             unused_addr_lsb;
  csr_sel_e         sel;
  logic             wr, rd;

  logic [31:0] bus_mode_q, ctrl_q, inten_q;
  logic [31:0] rx_base_q, tx_base_q, rx_cur_q, tx_cur_q;
  logic [31:0] status_q, set_mask, store_rdata, rd_mux;

  assign idx             = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign wr              = bus_valid & bus_write;
  assign rd              = bus_valid & ~bus_write;

  eth_dma_csr_decode #(.IDX_W(IDX_W), .STORE_WORDS(STORE_WORDS)) u_decode (
    .idx (idx),
    .sel (sel)
  );

  always_comb begin
    set_mask = '0;
    if (evt_tx_done) begin
      set_mask[ST_TX_DONE] = 1'b1;
      set_mask[ST_NORMAL]  = 1'b1;
    end
    if (evt_rx_done) begin
      set_mask[ST_RX_DONE] = 1'b1;
      set_mask[ST_NORMAL]  = 1'b1;
    end
    if (evt_rx_nobuf) begin
      set_mask[ST_RX_NOBUF] = 1'b1;
      set_mask[ST_ABNORMAL] = 1'b1;
    end
  end

  eth_dma_csr_status #(.W(32)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (wr && sel == SEL_STATUS),
    .clr_mask (bus_wdata),
    .set_mask (set_mask),
    .status   (status_q)
  );

  eth_dma_csr_store #(.WORDS(STORE_WORDS), .DW(32)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr && sel == SEL_STORE),
    .idx   (idx[STORE_AW-1:0]),
    .wdata (bus_wdata),
    .rdata (store_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_mode_q <= '0;
      ctrl_q     <= '0;
      inten_q    <= '0;
      rx_base_q  <= '0;
      tx_base_q  <= '0;
      rx_cur_q   <= '0;
      tx_cur_q   <= '0;
      tx_poll    <= 1'b0;
    end else begin
      tx_poll <= wr && sel == SEL_TXPOLL;
      if (wr) begin
        case (sel)
          SEL_BUSMODE: bus_mode_q <= {bus_wdata[31:1], 1'b0};
          SEL_CTRL:    ctrl_q     <= bus_wdata;
          SEL_INTEN:   inten_q    <= bus_wdata;
          SEL_RXBASE: begin
            rx_base_q <= bus_wdata;
            rx_cur_q  <= bus_wdata;
          end
          SEL_TXBASE: begin
            tx_base_q <= bus_wdata;
            tx_cur_q  <= bus_wdata;
          end
          SEL_RXCUR:   rx_cur_q   <= bus_wdata;
          SEL_TXCUR:   tx_cur_q   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_VERSION: rd_mux = VERSION_WORD;
      SEL_BUSMODE: rd_mux = bus_mode_q;
      SEL_RXBASE:  rd_mux = rx_base_q;
      SEL_TXBASE:  rd_mux = tx_base_q;
      SEL_STATUS:  rd_mux = status_q;
      SEL_CTRL:    rd_mux = ctrl_q;
      SEL_INTEN:   rd_mux = inten_q;
      SEL_RXCUR:   rd_mux = rx_cur_q;
      SEL_TXCUR:   rd_mux = tx_cur_q;
      SEL_STORE:   rd_mux = store_rdata;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_mux;
    end
  end

  assign irq          = |(status_q & inten_q);
  assign rx_enable    = ctrl_q[CT_RX_RUN];
  assign tx_start     = ctrl_q[CT_TX_RUN];
  assign rx_ring_base = rx_base_q;
  assign tx_ring_base = tx_base_q;
  assign rx_desc_ptr  = rx_cur_q;
  assign tx_desc_ptr  = tx_cur_q;

endmodule

// File: rtl/eth_dma_csr_chk.sv
module eth_dma_csr_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rd_valid,
  input logic              evt_tx_done,
  input logic              evt_rx_nobuf,
  input logic              tx_poll,
  input logic [31:0]       tx_desc_ptr,
  input logic [31:0]       status_q
);

  logic [ADDR_W-3:0] cidx;
  assign cidx = bus_addr[ADDR_W-1:2];

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && cidx == 'h3C5 && bus_wdata[0] && !evt_tx_done) |=> !status_q[0]);

  assert_tx_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx_done |=> (status_q[0] && status_q[16]));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_nobuf |=> (status_q[7] && status_q[15]));

  assert_tx_base_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && cidx == 'h3C4) |=> tx_desc_ptr == $past(bus_wdata));

  assert_poll_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |-> $past(bus_valid && bus_write && cidx == 'h3C1));

endmodule

bind eth_dma_csr eth_dma_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .rd_valid     (rd_valid),
  .evt_tx_done  (evt_tx_done),
  .evt_rx_nobuf (evt_rx_nobuf),
  .tx_poll      (tx_poll),
  .tx_desc_ptr  (tx_desc_ptr),
  .status_q     (status_q)
);

// File: tb/eth_dma_csr_tb_top.sv
module eth_dma_csr_tb_top;

  localparam int ADDR_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic evt_tx_done = 1'b0, evt_rx_done = 1'b0, evt_rx_nobuf = 1'b0;
  logic rd_valid, irq, tx_poll, rx_enable, tx_start;
  logic [31:0] rd_data, rx_ring_base, tx_ring_base, rx_desc_ptr, tx_desc_ptr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  eth_dma_csr #(.ADDR_W(ADDR_W), .STORE_WORDS(1024)) dut_i (.*);

  // ---------------- reference model ----------------
  logic [31:0] m_bus, m_ctrl, m_ie, m_st, m_rxb, m_txb, m_rxc, m_txc, m_rdd;
  logic        m_rdv, m_poll;
  logic [31:0] m_mem [int];

  function automatic logic [31:0] m_read(int ix);
    case (ix)
      'h008: return 32'h1012;
      'h3C0: return m_bus;
      'h3C1: return 32'h0;
      'h3C3: return m_rxb;
      'h3C4: return m_txb;
      'h3C5: return m_st;
      'h3C6: return m_ctrl;
      'h3C7: return m_ie;
      'h3D2: return m_txc;
      'h3D3: return m_rxc;
      default: return (ix < 1024 && m_mem.exists(ix)) ? m_mem[ix] : 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bus = 0; m_ctrl = 0; m_ie = 0; m_st = 0;
      m_rxb = 0; m_txb = 0; m_rxc = 0; m_txc = 0;
      m_rdd = 0; m_rdv = 0; m_poll = 0;
      m_mem.delete();
    end else begin
      automatic int ix = int'(bus_addr >> 2);
      automatic logic [31:0] setm = 0;
      automatic logic [31:0] clrm = 0;
      m_rdv  = bus_valid && !bus_write;
      if (m_rdv) m_rdd = m_read(ix);
      m_poll = bus_valid && bus_write && ix == 'h3C1;
      if (evt_tx_done)  setm = setm | 32'h0001_0001;
      if (evt_rx_done)  setm = setm | 32'h0001_0040;
      if (evt_rx_nobuf) setm = setm | 32'h0000_8080;
      if (bus_valid && bus_write && ix == 'h3C5) clrm = bus_wdata;
      m_st = (m_st & ~clrm) | setm;
      if (bus_valid && bus_write) begin
        case (ix)
          'h008, 'h3C1, 'h3C5: ;
          'h3C0: m_bus = bus_wdata & ~32'h1;
          'h3C3: begin m_rxb = bus_wdata; m_rxc = bus_wdata; end
          'h3C4: begin m_txb = bus_wdata; m_txc = bus_wdata; end
          'h3C6: m_ctrl = bus_wdata;
          'h3C7: m_ie = bus_wdata;
          'h3D2: m_txc = bus_wdata;
          'h3D3: m_rxc = bus_wdata;
          default: if (ix < 1024) m_mem[ix] = bus_wdata;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 irq", {31'd0, irq}, {31'd0, |(m_st & m_ie)});
      chk("R8 tx_poll", {31'd0, tx_poll}, {31'd0, m_poll});
      chk("R11 rx_enable", {31'd0, rx_enable}, {31'd0, m_ctrl[1]});
      chk("R11 tx_start", {31'd0, tx_start}, {31'd0, m_ctrl[13]});
      chk("R2 rd_valid", {31'd0, rd_valid}, {31'd0, m_rdv});
      if (m_rdv) chk("R2 rd_data", rd_data, m_rdd);
      chk("R7 rx_ring_base", rx_ring_base, m_rxb);
      chk("R7 tx_ring_base", tx_ring_base, m_txb);
      chk("R7 rx_desc_ptr", rx_desc_ptr, m_rxc);
      chk("R7 tx_desc_ptr", tx_desc_ptr, m_txc);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int ix, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = ADDR_W'(ix << 2); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_chk(int ix, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = ADDR_W'(ix << 2);
    @(negedge clk);
    bus_valid = 0;
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    evt_tx_done  = (which == 0);
    evt_rx_done  = (which == 1);
    evt_rx_nobuf = (which == 2);
    @(negedge clk);
    evt_tx_done = 0; evt_rx_done = 0; evt_rx_nobuf = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 tx_poll", {31'd0, tx_poll}, 0);
    rd_chk('h3C5, 0, "R1 status");
    rd_chk('h3C6, 0, "R1 control");
    rd_chk('h100, 0, "R1 store");

    // R10 version
    rd_chk('h008, 32'h1012, "R10 version");
    wr('h008, 32'hFFFF_FFFF);
    rd_chk('h008, 32'h1012, "R10 version after write");

    // R9 bus mode bit 0 forced low
    wr('h3C0, 32'h0000_0081);
    rd_chk('h3C0, 32'h0000_0080, "R9 bus mode");

    // R7 ring bases reload pointers
    wr('h3C3, 32'h1000_0000);
    rd_chk('h3D3, 32'h1000_0000, "R7 rx pointer");
    wr('h3C4, 32'h2000_0040);
    rd_chk('h3D2, 32'h2000_0040, "R7 tx pointer");
    wr('h3D2, 32'h0000_0055);
    rd_chk('h3D2, 32'h0000_0055, "R7 tx pointer direct");
    chk("R7 tx base kept", tx_ring_base, 32'h2000_0040);
    wr('h3C4, 32'h2000_0040);
    chk("R7 tx pointer rewind", tx_desc_ptr, 32'h2000_0040);

    // R8 poll strobe
    wr('h3C1, 32'hABCD_0000);
    chk("R8 poll high", {31'd0, tx_poll}, 1);
    @(negedge clk);
    chk("R8 poll low", {31'd0, tx_poll}, 0);
    rd_chk('h3C1, 0, "R8 poll not stored");

    // R4 / R6 / R3 events, enables, clears
    pulse(0);
    rd_chk('h3C5, 32'h0001_0001, "R4 tx event");
    chk("R6 irq masked", {31'd0, irq}, 0);
    wr('h3C7, 32'h0000_0001);
    chk("R6 irq raised", {31'd0, irq}, 1);
    wr('h3C5, 32'h0000_0001);
    rd_chk('h3C5, 32'h0001_0000, "R3 partial clear");
    chk("R6 irq dropped", {31'd0, irq}, 0);
    pulse(1);
    rd_chk('h3C5, 32'h0001_0040, "R4 rx event");
    pulse(2);
    rd_chk('h3C5, 32'h0001_80C0, "R4 no-buffer event");
    wr('h3C7, 32'h0000_8000);
    chk("R6 irq abnormal", {31'd0, irq}, 1);

    // R5 event and clear in the same cycle
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = ADDR_W'('h3C5 << 2);
    bus_wdata = 32'h0000_8080; evt_rx_nobuf = 1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; evt_rx_nobuf = 0;
    rd_chk('h3C5, 32'h0001_80C0, "R5 set wins");
    wr('h3C5, 32'hFFFF_FFFF);
    rd_chk('h3C5, 0, "R3 full clear");
    chk("R6 irq after clear", {31'd0, irq}, 0);

    // R11 control outputs
    wr('h3C6, 32'h0000_2002);
    chk("R11 rx_enable on", {31'd0, rx_enable}, 1);
    chk("R11 tx_start on", {31'd0, tx_start}, 1);
    wr('h3C6, 32'h0000_0002);
    chk("R11 tx_start off", {31'd0, tx_start}, 0);

    // R12 plain storage and unmapped space
    wr('h100, 32'hDEAD_BEEF);
    rd_chk('h100, 32'hDEAD_BEEF, "R12 store word");
    wr('h3C2, 32'h0000_1234);
    rd_chk('h3C2, 32'h0000_1234, "R12 rx poll word");
    wr('h800, 32'h1111_2222);
    rd_chk('h800, 0, "R12 above array");
    rd_chk('h100, 32'hDEAD_BEEF, "R12 store intact");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule